// File: doc/BRIEF.md
# Two-Cache MSI Snooping Coherence Controller

This block keeps two private write-back caches coherent over one shared bus to memory. Each processor has its own request port: a read or write of one data word at a byte-free word address. A read returns the word and a write returns the value it stored, and every request ends with a one-cycle completion pulse. Each cache is direct-mapped with a small number of lines. Every line holds one word, a tag and a three-valued coherence state: Invalid, Shared or Modified.

Hits that need no permission are served locally. A read of a Shared or Modified line and a write of a Modified line both complete without bus traffic. Every other access becomes a bus transaction. A read miss asks for a shared copy. A write that lacks ownership asks for an exclusive copy and removes the peer's copy. A single sequencer runs one transaction at a time. When a transaction finds the peer holding the line Modified, the sequencer first writes that line back to memory and downgrades it. The requester stays stalled and then competes for the bus again. Its data always comes from memory, never from the other cache. A Modified line displaced by a direct-mapped conflict is written back before the new line is fetched. Memory sits outside the block and answers a read one cycle after it is issued.

Top module: `msi_pair_ctrl`

## Requirements
- R1: After reset every line in both caches is Invalid; the probe outputs report state codes 0 = Invalid, 1 = Shared, 2 = Modified for the line at `probe_addr` (Invalid when the tag does not match).
- R2: A read miss issues exactly one memory read. It installs the line as Shared and returns the word memory supplied.
- R3: A read that hits a Shared or Modified line completes with the cached word and causes no memory read or write. Both caches may hold the same line Shared at once.
- R4: A write to a line that is Invalid or Shared in the writing cache gains ownership through the bus. Afterwards the writer holds the line Modified and the peer holds it Invalid.
- R5: A write that hits a Modified line updates only the local copy and causes no memory read or write.
- R6: When a shared-copy request meets a Modified line in the peer, that line is written to memory and the peer drops to Shared.
- R7: When an ownership request meets a Modified line in the peer, that line is written to memory and the peer drops to Invalid. At no time are both caches Modified, or one Modified and the other Shared, for the same line.
- R8: A requester that caused a write-back is stalled until the write-back finishes. It then reissues its transaction and receives the just-written value from memory.
- R9: When both caches raise a bus request in the same cycle with no retry pending, processor 1 is served first.
- R10: The retry of a stalled requester is granted ahead of any request that the other cache raised during the write-back.
- R11: A miss whose direct-mapped slot holds a Modified line with another tag writes that line back to memory before reading the new line.
- R12: Each request produces exactly one completion pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p1_req | input | 1 | Processor 1 request, held until p1_done |
| p1_we | input | 1 | Processor 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Processor 1 word address |
| p1_wdata | input | DATA_W | Processor 1 write data |
| p1_rdata | output | DATA_W | Processor 1 returned word |
| p1_done | output | 1 | Processor 1 completion pulse |
| p2_req | input | 1 | Processor 2 request, held until p2_done |
| p2_we | input | 1 | Processor 2 write (1) or read (0) |
| p2_addr | input | ADDR_W | Processor 2 word address |
| p2_wdata | input | DATA_W | Processor 2 write data |
| p2_rdata | output | DATA_W | Processor 2 returned word |
| p2_done | output | 1 | Processor 2 completion pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after mem_rd |
| probe_addr | input | ADDR_W | Address whose state is reported |
| probe_st1 | output | 2 | State of probe_addr in cache 1 |
| probe_st2 | output | 2 | State of probe_addr in cache 2 |

## Verification
The hardest case to reach is the retry race. A requester must be stalled behind a write-back, and the owner of the flushed line must raise a fresh miss while that write-back is still running. Only then do two requests meet at the arbiter with the retry pending. The bench first makes processor 1 own a line. It then starts a processor 2 read of that line, and one cycle later starts a processor 1 miss to a different slot. It logs the order of memory reads to show that the stalled read goes first. The five-step one-address sequence, the direct-mapped eviction and a same-cycle pair of misses cover the other transitions. After each step the bench checks both caches' probe states, the bench memory contents and the counts of memory traffic.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_e;

  typedef enum logic {
    OP_RD  = 1'b0,
    OP_RDX = 1'b1
  } bus_op_e;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_CHECK,
    BS_FLUSH,
    BS_EVICT,
    BS_READ,
    BS_FILL
  } bus_st_e;

  // state a line takes when the peer's transaction is applied to it
  function automatic line_st_e snoop_next(line_st_e cur, bus_op_e op);
    if (op == OP_RDX) return LN_I;
    if (cur == LN_M)  return LN_S;
    return cur;
  endfunction

  // state installed when the owner's transaction completes
  function automatic line_st_e fill_state(logic we);
    return we ? LN_M : LN_S;
  endfunction

  // an access the cache may finish on its own, given a tag match
  function automatic logic local_serve(line_st_e cur, logic we);
    return (cur == LN_M) || (cur == LN_S && !we);
  endfunction

  // index of the granted cache: a pending retry first, otherwise cache 0
  function automatic logic pick_grant(logic [1:0] req, logic retry_pend, logic retry_who);
    if (retry_pend && req[retry_who]) return retry_who;
    if (req[0]) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/msi_line_cache.sv
module msi_line_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  input  logic              hold,
  output logic              bus_req,
  output bus_op_e           bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              vic_dirty,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [DATA_W-1:0] vic_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [ADDR_W-1:0] snp_addr,
  input  bus_op_e           snp_op,
  input  logic              snp_apply,
  output logic              snp_hit_m,
  output logic [DATA_W-1:0] snp_data,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [1:0]        probe_state
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {CC_IDLE, CC_WAIT, CC_RESP} cc_st_e;

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  cc_st_e            cst_q;
  logic              r_we_q;
  logic [ADDR_W-1:0] r_addr_q;
  logic [DATA_W-1:0] r_wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // lookup of the incoming processor access
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic             a_match, accept, serve_now;
  assign a_idx     = cpu_addr[IDX_W-1:0];
  assign a_tag     = cpu_addr[ADDR_W-1:IDX_W];
  assign a_match   = (st_q[a_idx] != LN_I) && (tag_q[a_idx] == a_tag);
  assign accept    = (cst_q == CC_IDLE) && cpu_req && !hold;
  assign serve_now = a_match && local_serve(st_q[a_idx], cpu_we);

  // pending miss
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic [DATA_W-1:0] fill_word;
  assign r_idx     = r_addr_q[IDX_W-1:0];
  assign r_tag     = r_addr_q[ADDR_W-1:IDX_W];
  assign fill_word = r_we_q ? r_wdata_q : fill_data;

  // snoop lookup
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_match;
  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign s_match = (st_q[s_idx] != LN_I) && (tag_q[s_idx] == s_tag);

  // probe lookup
  logic [IDX_W-1:0] p_idx;
  logic [TAG_W-1:0] p_tag;
  assign p_idx = probe_addr[IDX_W-1:0];
  assign p_tag = probe_addr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst_q     <= CC_IDLE;
      r_we_q    <= 1'b0;
      r_addr_q  <= '0;
      r_wdata_q <= '0;
      rdata_q   <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      case (cst_q)
        CC_IDLE: begin
          if (accept) begin
            if (serve_now) begin
              if (cpu_we) dat_q[a_idx] <= cpu_wdata;
              rdata_q <= cpu_we ? cpu_wdata : dat_q[a_idx];
              cst_q   <= CC_RESP;
            end else begin
              r_we_q    <= cpu_we;
              r_addr_q  <= cpu_addr;
              r_wdata_q <= cpu_wdata;
              cst_q     <= CC_WAIT;
            end
          end
        end
        CC_WAIT: begin
          if (fill_valid) begin
            tag_q[r_idx] <= r_tag;
            st_q[r_idx]  <= fill_state(r_we_q);
            dat_q[r_idx] <= fill_word;
            rdata_q      <= fill_word;
            cst_q        <= CC_RESP;
          end
        end
        default: cst_q <= CC_IDLE;
      endcase
      if (snp_apply && s_match) st_q[s_idx] <= snoop_next(st_q[s_idx], snp_op);
    end
  end

  assign cpu_rdata   = rdata_q;
  assign cpu_done    = (cst_q == CC_RESP);
  assign bus_req     = (cst_q == CC_WAIT);
  assign bus_op      = r_we_q ? OP_RDX : OP_RD;
  assign bus_addr    = r_addr_q;
  assign vic_dirty   = (st_q[r_idx] == LN_M) && (tag_q[r_idx] != r_tag);
  assign vic_addr    = {tag_q[r_idx], r_idx};
  assign vic_data    = dat_q[r_idx];
  assign snp_hit_m   = s_match && (st_q[s_idx] == LN_M);
  assign snp_data    = dat_q[s_idx];
  assign probe_state = (tag_q[p_idx] == p_tag) ? st_q[p_idx] : LN_I;

endmodule

// File: rtl/msi_bus_arb.sv
module msi_bus_arb
  import msi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_req,
  input  logic       arb_open,
  input  logic       flush_ev,
  input  logic       flush_who,
  output logic       gnt_any,
  output logic       gnt_who,
  output logic       retry_pend
);

  logic retry_who_q;
  logic retry_pend_q;

  assign gnt_any    = |bus_req;
  assign gnt_who    = pick_grant(bus_req, retry_pend_q, retry_who_q);
  assign retry_pend = retry_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_pend_q <= 1'b0;
      retry_who_q  <= 1'b0;
    end else if (flush_ev) begin
      retry_pend_q <= 1'b1;
      retry_who_q  <= flush_who;
    end else if (arb_open && gnt_any) begin
      retry_pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/msi_pair_ctrl.sv
module msi_pair_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              p1_done,
  input  logic              p2_req,
  input  logic              p2_we,
  input  logic [ADDR_W-1:0] p2_addr,
  input  logic [DATA_W-1:0] p2_wdata,
  output logic [DATA_W-1:0] p2_rdata,
  output logic              p2_done,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [1:0]        probe_st1,
  output logic [1:0]        probe_st2
);

  localparam int NCACHE = 2;

  // per-cache processor side
  logic [NCACHE-1:0] c_req, c_we, c_done;
  logic [ADDR_W-1:0] c_addr  [NCACHE];
  logic [DATA_W-1:0] c_wdata [NCACHE];
  logic [DATA_W-1:0] c_rdata [NCACHE];

  // per-cache bus side
  logic [NCACHE-1:0] bus_req_w, c_vic_dirty, c_hit_m, c_fill, c_apply;
  bus_op_e           c_op       [NCACHE];
  logic [ADDR_W-1:0] c_bus_addr [NCACHE];
  logic [ADDR_W-1:0] c_vic_addr [NCACHE];
  logic [DATA_W-1:0] c_vic_data [NCACHE];
  logic [DATA_W-1:0] c_snp_data [NCACHE];
  logic [1:0]        c_probe    [NCACHE];

  assign c_req[0] = p1_req;   assign c_req[1] = p2_req;
  assign c_we[0]  = p1_we;    assign c_we[1]  = p2_we;
  assign c_addr[0]  = p1_addr;  assign c_addr[1]  = p2_addr;
  assign c_wdata[0] = p1_wdata; assign c_wdata[1] = p2_wdata;
  assign p1_rdata = c_rdata[0]; assign p2_rdata = c_rdata[1];
  assign p1_done  = c_done[0];  assign p2_done  = c_done[1];
  assign probe_st1 = c_probe[0];
  assign probe_st2 = c_probe[1];

  // bus sequencer state
  bus_st_e bst_q;
  logic    owner_q;
  logic    other_w;
  assign other_w = ~owner_q;

  // named events for the checker
  logic grant_ev, grant_who, flush_ev, fill_ev, gnt_any, retry_pend_q;
  assign grant_ev = (bst_q == BS_IDLE) && gnt_any;
  assign flush_ev = (bst_q == BS_FLUSH);
  assign fill_ev  = (bst_q == BS_FILL);

  msi_bus_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req_w),
    .arb_open   (bst_q == BS_IDLE),
    .flush_ev   (flush_ev),
    .flush_who  (owner_q),
    .gnt_any    (gnt_any),
    .gnt_who    (grant_who),
    .retry_pend (retry_pend_q)
  );

  for (genvar g = 0; g < NCACHE; g++) begin : g_cache
    localparam logic ME  = (g == 0) ? 1'b0 : 1'b1;
    localparam logic OTH = ~ME;

    assign c_fill[g]  = fill_ev && (owner_q == ME);
    assign c_apply[g] = (owner_q == OTH) &&
                        (((bst_q == BS_CHECK) && !c_hit_m[g]) || (bst_q == BS_FLUSH));

    msi_line_cache #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_cache (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (c_req[g]),
      .cpu_we      (c_we[g]),
      .cpu_addr    (c_addr[g]),
      .cpu_wdata   (c_wdata[g]),
      .cpu_rdata   (c_rdata[g]),
      .cpu_done    (c_done[g]),
      .hold        (flush_ev),
      .bus_req     (bus_req_w[g]),
      .bus_op      (c_op[g]),
      .bus_addr    (c_bus_addr[g]),
      .vic_dirty   (c_vic_dirty[g]),
      .vic_addr    (c_vic_addr[g]),
      .vic_data    (c_vic_data[g]),
      .fill_valid  (c_fill[g]),
      .fill_data   (mem_rdata),
      .snp_addr    (c_bus_addr[OTH]),
      .snp_op      (c_op[OTH]),
      .snp_apply   (c_apply[g]),
      .snp_hit_m   (c_hit_m[g]),
      .snp_data    (c_snp_data[g]),
      .probe_addr  (probe_addr),
      .probe_state (c_probe[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst_q   <= BS_IDLE;
      owner_q <= 1'b0;
    end else begin
      case (bst_q)
        BS_IDLE: if (grant_ev) begin
          owner_q <= grant_who;
          bst_q   <= BS_CHECK;
        end
        BS_CHECK: begin
          if (c_hit_m[other_w])          bst_q <= BS_FLUSH;
          else if (c_vic_dirty[owner_q]) bst_q <= BS_EVICT;
          else                           bst_q <= BS_READ;
        end
        BS_FLUSH: bst_q <= BS_IDLE;
        BS_EVICT: bst_q <= BS_READ;
        BS_READ:  bst_q <= BS_FILL;
        default:  bst_q <= BS_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (bst_q == BS_READ);
    mem_wr    = (bst_q == BS_FLUSH) || (bst_q == BS_EVICT);
    mem_addr  = c_bus_addr[owner_q];
    mem_wdata = c_snp_data[other_w];
    if (bst_q == BS_EVICT) begin
      mem_addr  = c_vic_addr[owner_q];
      mem_wdata = c_vic_data[owner_q];
    end
  end

endmodule

// File: rtl/msi_pair_chk.sv
module msi_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       p1_done,
  input logic       p2_done,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [1:0] probe_st1,
  input logic [1:0] probe_st2,
  input logic       grant_ev,
  input logic       grant_who,
  input logic       flush_ev,
  input logic       fill_ev,
  input logic       owner_q,
  input logic [1:0] bus_req_w,
  input logic       retry_pend_q
);

  assert_excl_c1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_st1 == 2'd2) |-> (probe_st2 == 2'd0));

  assert_excl_c2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_st2 == 2'd2) |-> (probe_st1 == 2'd0));

  assert_flush_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ev |-> (mem_wr && !mem_rd));

  assert_retry_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ev |=> (grant_ev && (grant_who == $past(owner_q))));

  assert_p1_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_ev && (bus_req_w == 2'b11) && !retry_pend_q) |-> (grant_who == 1'b0));

  assert_fill_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |-> $past(mem_rd));

  assert_p1_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    p1_done |=> !p1_done);

  assert_p2_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    p2_done |=> !p2_done);

endmodule

bind msi_pair_ctrl msi_pair_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .p1_done      (p1_done),
  .p2_done      (p2_done),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .probe_st1    (probe_st1),
  .probe_st2    (probe_st2),
  .grant_ev     (grant_ev),
  .grant_who    (grant_who),
  .flush_ev     (flush_ev),
  .fill_ev      (fill_ev),
  .owner_q      (owner_q),
  .bus_req_w    (bus_req_w),
  .retry_pend_q (retry_pend_q)
);

// File: tb/msi_pair_ctrl_bench.sv
module msi_pair_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic p1_req = 0, p1_we = 0, p2_req = 0, p2_we = 0;
  logic [ADDR_W-1:0] p1_addr = '0, p2_addr = '0, probe_addr = '0;
  logic [DATA_W-1:0] p1_wdata = '0, p2_wdata = '0;
  logic [DATA_W-1:0] p1_rdata, p2_rdata, mem_wdata, mem_rdata;
  logic p1_done, p2_done, mem_rd, mem_wr;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0] probe_st1, probe_st2;

  msi_pair_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_msi_pair_ctrl (
    .clk(clk), .rst_n(rst_n),
    .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_rdata(p1_rdata), .p1_done(p1_done),
    .p2_req(p2_req), .p2_we(p2_we), .p2_addr(p2_addr), .p2_wdata(p2_wdata),
    .p2_rdata(p2_rdata), .p2_done(p2_done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .probe_addr(probe_addr),
    .probe_st1(probe_st1), .probe_st2(probe_st2)
  );

  function automatic logic [DATA_W-1:0] init_val(int a);
    return DATA_W'(16'h1000 + a * 7);
  endfunction

  // single-cycle memory model
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  int nrd = 0, nwr = 0, log_n = 0;
  logic [ADDR_W-1:0] rd_log [64];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << ADDR_W); i++) mem[i] <= init_val(i);
    end else begin
      if (mem_wr) begin mem[mem_addr] <= mem_wdata; nwr <= nwr + 1; end
      if (mem_rd) begin
        nrd <= nrd + 1;
        if (log_n < 64) begin rd_log[log_n] <= mem_addr; log_n <= log_n + 1; end
      end
    end
    mem_rdata <= mem[mem_addr];
  end

  int nvec = 0, nbad = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_st(input string rq, input logic [ADDR_W-1:0] a,
                        input logic [1:0] e1, input logic [1:0] e2);
    probe_addr = a;
    #1;
    chk({rq, " cache1 state"}, 32'(probe_st1), 32'(e1));
    chk({rq, " cache2 state"}, 32'(probe_st2), 32'(e2));
  endtask

  task automatic op(input int p, input logic we, input logic [ADDR_W-1:0] a,
                    input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd);
    int n;
    @(negedge clk);
    if (p == 1) begin p1_req = 1; p1_we = we; p1_addr = a; p1_wdata = wd; end
    else        begin p2_req = 1; p2_we = we; p2_addr = a; p2_wdata = wd; end
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((p == 1) ? p1_done : p2_done) == 1'b0 && n < 200);
    chk("R12 done seen", 32'(n < 200), 32'd1);
    rd = (p == 1) ? p1_rdata : p2_rdata;
    if (p == 1) p1_req = 0; else p2_req = 0;
    @(negedge clk);
    chk("R12 done one cycle", 32'((p == 1) ? p1_done : p2_done), 32'd0);
  endtask

  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SM = 2'd2;

  initial begin
    repeat (100000) @(posedge clk);
    nbad++; nvec++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd, rd2;
    logic [ADDR_W-1:0] a_a, a_c, a_d, a_e, a_f, a_g, a_g2;
    int rd0, wr0, lg0;
    a_a = 8'h25; a_c = 8'h40; a_d = 8'h52; a_e = 8'h61; a_f = 8'h73;
    a_g = 8'h0A; a_g2 = 8'h0E;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_st("R1 reset", a_a, SI, SI);
    chk("R12 reset done", 32'({p1_done, p2_done}), 32'd0);

    // step 1: P1 read A
    rd0 = nrd;
    op(1, 0, a_a, '0, rd);
    chk("R2 read miss data", 32'(rd), 32'(init_val(a_a)));
    chk("R2 one mem read", 32'(nrd - rd0), 32'd1);
    chk_st("R2 after P1 read", a_a, SS, SI);

    // step 2: P2 read A
    op(2, 0, a_a, '0, rd);
    chk("R3 second reader data", 32'(rd), 32'(init_val(a_a)));
    chk_st("R3 both shared", a_a, SS, SS);

    // read hit in Shared
    rd0 = nrd; wr0 = nwr;
    op(1, 0, a_a, '0, rd);
    chk("R3 hit data", 32'(rd), 32'(init_val(a_a)));
    chk("R3 hit no traffic", 32'((nrd - rd0) + (nwr - wr0)), 32'd0);

    // step 3: P2 write A (upgrade)
    op(2, 1, a_a, 16'hBEEF, rd);
    chk_st("R4 writer owns", a_a, SI, SM);
    chk("R4 memory untouched", 32'(mem[a_a]), 32'(init_val(a_a)));

    // write hit in Modified
    rd0 = nrd; wr0 = nwr;
    op(2, 1, a_a, 16'hBEE1, rd);
    chk("R5 no traffic", 32'((nrd - rd0) + (nwr - wr0)), 32'd0);
    chk_st("R5 still modified", a_a, SI, SM);
    op(2, 0, a_a, '0, rd);
    chk("R5 local value", 32'(rd), 32'h0000BEE1);

    // step 4: P1 write A, P2 holds it Modified
    rd0 = nrd; wr0 = nwr;
    op(1, 1, a_a, 16'hCAFE, rd);
    chk("R7 flushed value", 32'(mem[a_a]), 32'h0000BEE1);
    chk("R7 one write-back", 32'(nwr - wr0), 32'd1);
    chk("R8 retry reads memory", 32'(nrd - rd0), 32'd1);
    chk_st("R7 ownership moved", a_a, SM, SI);

    // step 5: P2 read A, P1 holds it Modified
    op(2, 0, a_a, '0, rd);
    chk("R8 retry data from memory", 32'(rd), 32'h0000CAFE);
    chk("R6 flushed value", 32'(mem[a_a]), 32'h0000CAFE);
    chk_st("R6 holder to shared", a_a, SS, SS);

    // same-cycle misses
    lg0 = log_n;
    fork
      op(1, 0, a_c, '0, rd);
      op(2, 0, a_d, '0, rd2);
    join
    chk("R9 first read is P1", 32'(rd_log[lg0]), 32'(a_c));
    chk("R9 second read is P2", 32'(rd_log[lg0 + 1]), 32'(a_d));
    chk("R9 P1 data", 32'(rd), 32'(init_val(a_c)));
    chk("R9 P2 data", 32'(rd2), 32'(init_val(a_d)));

    // retry beats a new request raised during the write-back
    op(1, 1, a_e, 16'h5A5A, rd);
    chk_st("R10 setup owner", a_e, SM, SI);
    lg0 = log_n;
    fork
      op(2, 0, a_e, '0, rd2);
      begin @(negedge clk); op(1, 0, a_f, '0, rd); end
    join
    chk("R10 retry read first", 32'(rd_log[lg0]), 32'(a_e));
    chk("R10 newer read second", 32'(rd_log[lg0 + 1]), 32'(a_f));
    chk("R10 retry data", 32'(rd2), 32'h00005A5A);
    chk("R10 other data", 32'(rd), 32'(init_val(a_f)));
    chk_st("R10 shared after", a_e, SS, SS);

    // direct-mapped eviction of a Modified line
    op(1, 1, a_g, 16'h7777, rd);
    rd0 = nrd; wr0 = nwr;
    op(1, 0, a_g2, '0, rd);
    chk("R11 victim written", 32'(mem[a_g]), 32'h00007777);
    chk("R11 one write one read", 32'((nwr - wr0) * 16 + (nrd - rd0)), 32'h11);
    chk("R11 new line data", 32'(rd), 32'(init_val(a_g2)));
    chk_st("R11 victim gone", a_g, SI, SI);
    chk_st("R11 new line shared", a_g2, SS, SI);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule